// File: doc/BRIEF.md
# Direct Convolution Address Sequencer

This block drives a direct convolution over four-dimensional tensors. It starts from a runtime configuration: batch count, square input size, input channel count, output channel count, square kernel size, stride and padding. It then visits every index combination of the seven nested convolution loops, one combination per clock cycle. For each combination it presents flat addresses for the input, kernel and output tensors. A valid flag marks the combinations whose input coordinates fall inside the input tensor. Combinations that fall outside are visited but contribute nothing, so padding behaves as zeros without any zeros being stored.

The surrounding memory returns the input and kernel operands in the same cycle as the addresses. An internal multiply-accumulate datapath sums the products that belong to one output element. It writes the finished sum to the output address one cycle after that element's last step. A start pulse launches a run and done pulses once when the run ends. A configuration that cannot produce an output (zero stride, or a kernel wider than the padded input) raises an error flag and is never run.

Top module: `conv_seq`

## Requirements
- R1: While reset is held and directly after it, busy, done, cfg_err, req_active, req_valid, req_first, req_last and wr_valid are 0 and out_size is 0.
- R2: After an accepted start, out_size equals floor((in_size + 2*pad - k_size)/stride) + 1 by the first step and holds that value through the run.
- R3: A run performs exactly batch*out_size*out_size*out_ch*k_size*k_size*in_ch steps on consecutive cycles, with req_active high, in the loop order batch, output row, output column, output channel, kernel row, kernel column, input channel (outermost first). req_active falls directly after the last step.
- R4: For a step, with iy = orow*stride + krow - pad and ix = ocol*stride + kcol - pad (signed), req_valid is 1 exactly when 0 <= iy < in_size and 0 <= ix < in_size. When req_valid is 1, in_addr = ((b*in_size + iy)*in_size + ix)*in_ch + ich (layout [batch][row][col][channel]).
- R5: ker_addr = ((och*k_size + krow)*k_size + kcol)*in_ch + ich and out_addr = ((b*out_size + orow)*out_size + ocol)*out_ch + och on every step.
- R6: req_first is 1 exactly on steps with krow = kcol = ich = 0. req_last is 1 exactly on steps with krow = kcol = k_size-1 and ich = in_ch-1.
- R7: One cycle after every step with req_last, wr_valid is 1 for one cycle. wr_addr is then that step's out_addr, and wr_data is the signed sum of in_data*ker_data over the element's steps that had req_valid, or 0 when none had. wr_valid is 0 in all other cycles.
- R8: done is 1 for exactly one cycle, one cycle after the final write. busy is 0 while done is 1.
- R9: A start with stride 0, or with k_size > in_size + 2*pad, sets cfg_err in the next cycle. No step, write or done follows, and busy stays 0. The next accepted start clears cfg_err.
- R10: A start pulse while busy is 1 is ignored: the running walk, its writes and cfg_err are unaffected, even when the pulse carries a faulty configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled when not busy |
| cfg_batch | input | DIM_W | Batch count |
| cfg_in_size | input | DIM_W | Input rows and columns |
| cfg_in_ch | input | DIM_W | Input (and kernel) channel count |
| cfg_out_ch | input | DIM_W | Output channel count |
| cfg_k_size | input | DIM_W | Kernel rows and columns |
| cfg_stride | input | DIM_W | Sliding step |
| cfg_pad | input | DIM_W | Implicit zero border width |
| in_data | input | DATA_W | Signed input operand at in_addr, same cycle |
| ker_data | input | DATA_W | Signed kernel operand at ker_addr, same cycle |
| busy | output | 1 | Run or setup in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cfg_err | output | 1 | Last start carried a faulty configuration |
| out_size | output | DIM_W+2 | Computed output rows and columns |
| req_active | output | 1 | A loop step is presented this cycle |
| req_valid | output | 1 | The step lies inside the input tensor |
| req_first | output | 1 | First step of an output element |
| req_last | output | 1 | Last step of an output element |
| in_addr | output | ADDR_W | Input tensor flat address |
| ker_addr | output | ADDR_W | Kernel tensor flat address |
| out_addr | output | ADDR_W | Output tensor flat address of the current element |
| wr_valid | output | 1 | Output element write strobe |
| wr_addr | output | ADDR_W | Output write address |
| wr_data | output | ACC_W | Accumulated output value |

## Verification
The assertions assume that every count in the configuration (batch, sizes, channels) is non-zero. They also assume that every tensor offset fits in ADDR_W bits, and that the operands arrive combinationally in the cycle of their addresses. Under these assumptions the walk is a fixed chain of counters, and the relations between first, last, output address and write strobe hold. The stimulus uses small tensors, with at most two batches and kernels up to three wide, so all offsets stay far below the address range. It never applies a zero count. Its memories are pure functions of the address, so each operand is defined in the same cycle.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    parameter int DIM_W  = 6;
    parameter int ADDR_W = 16;

    localparam int SPAN_W = DIM_W + 2;
    localparam int OFF_W  = ADDR_W + 2;

    typedef logic [DIM_W-1:0]         dim_t;
    typedef logic [SPAN_W-1:0]        span_t;
    typedef logic [ADDR_W-1:0]        addr_t;
    typedef logic signed [OFF_W-1:0]  off_t;

    typedef struct packed {
        dim_t batch;
        dim_t in_size;
        dim_t in_ch;
        dim_t out_ch;
        dim_t k_size;
        dim_t stride;
        dim_t pad;
    } cfg_t;

    // Geometry derived once per run; every per-step update is an add.
    typedef struct packed {
        cfg_t  cfg;
        span_t out_size;
        off_t  row_pitch;   // in_size * in_ch
        off_t  img_pitch;   // in_size * in_size * in_ch
        off_t  srow;        // stride * row_pitch
        off_t  scol;        // stride * in_ch
        off_t  prow;        // pad * row_pitch
        off_t  pcol;        // pad * in_ch
    } geo_t;

    typedef struct packed {
        logic  active;
        logic  valid;
        logic  first;
        logic  last;
        logic  final_step;
        addr_t in_addr;
        addr_t ker_addr;
        addr_t out_addr;
    } req_t;

    typedef enum logic {SU_IDLE, SU_DIV} setup_state_e;

    function automatic span_t padded_span(cfg_t c);
        return span_t'(c.in_size) + (span_t'(c.pad) << 1);
    endfunction

    function automatic logic cfg_bad(cfg_t c);
        return (c.stride == '0) || (span_t'(c.k_size) > padded_span(c));
    endfunction

    function automatic off_t to_off(dim_t d);
        return off_t'(d);
    endfunction

    function automatic off_t mul_off(off_t a, off_t b);
        off_t r;
        r = a * b;
        return r;
    endfunction

endpackage

// File: rtl/conv_seq_setup.sv
module conv_seq_setup
    import conv_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic idle_i,
    input  cfg_t cfg_i,
    output geo_t geo_o,
    output logic launch_o,
    output logic err_o,
    output logic busy_o
);

    setup_state_e state_q;
    span_t        rem_q;
    span_t        quo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SU_IDLE;
            geo_o    <= '0;
            rem_q    <= '0;
            quo_q    <= '0;
            launch_o <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            launch_o <= 1'b0;
            if (state_q == SU_IDLE) begin
                if (start_i && idle_i) begin
                    if (cfg_bad(cfg_i)) begin
                        err_o <= 1'b1;
                    end else begin
                        err_o           <= 1'b0;
                        geo_o.cfg       <= cfg_i;
                        geo_o.row_pitch <= mul_off(to_off(cfg_i.in_size), to_off(cfg_i.in_ch));
                        geo_o.img_pitch <= mul_off(mul_off(to_off(cfg_i.in_size), to_off(cfg_i.in_size)),
                                                   to_off(cfg_i.in_ch));
                        geo_o.srow      <= mul_off(mul_off(to_off(cfg_i.stride), to_off(cfg_i.in_size)),
                                                   to_off(cfg_i.in_ch));
                        geo_o.scol      <= mul_off(to_off(cfg_i.stride), to_off(cfg_i.in_ch));
                        geo_o.prow      <= mul_off(mul_off(to_off(cfg_i.pad), to_off(cfg_i.in_size)),
                                                   to_off(cfg_i.in_ch));
                        geo_o.pcol      <= mul_off(to_off(cfg_i.pad), to_off(cfg_i.in_ch));
                        rem_q           <= padded_span(cfg_i) - span_t'(cfg_i.k_size);
                        quo_q           <= '0;
                        state_q         <= SU_DIV;
                    end
                end
            end else begin
                // Restoring division by repeated subtraction, one step per cycle.
                if (rem_q >= span_t'(geo_o.cfg.stride)) begin
                    rem_q <= rem_q - span_t'(geo_o.cfg.stride);
                    quo_q <= quo_q + span_t'(1);
                end else begin
                    geo_o.out_size <= quo_q + span_t'(1);
                    launch_o       <= 1'b1;
                    state_q        <= SU_IDLE;
                end
            end
        end
    end

    assign busy_o = (state_q == SU_DIV);

endmodule

// File: rtl/conv_seq_walker.sv
module conv_seq_walker
    import conv_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch_i,
    input  geo_t geo_i,
    output req_t req_o
);

    logic  running_q;
    dim_t  n_q, oc_q, kr_q, kc_q, ic_q;
    span_t orow_q, ocol_q;
    off_t  iy_base_q, ix_base_q;
    off_t  n_off_q, row_off_q, col_off_q, kr_off_q, kc_off_q;
    addr_t ker_q, out_q;

    logic w_ic, w_kc, w_kr, w_oc, w_ocol, w_orow, w_n;
    logic lst, fst, vld;
    off_t iy, ix, in_sum;

    always_comb begin
        w_ic   = (ic_q   == geo_i.cfg.in_ch  - dim_t'(1));
        w_kc   = (kc_q   == geo_i.cfg.k_size - dim_t'(1));
        w_kr   = (kr_q   == geo_i.cfg.k_size - dim_t'(1));
        w_oc   = (oc_q   == geo_i.cfg.out_ch - dim_t'(1));
        w_ocol = (ocol_q == geo_i.out_size   - span_t'(1));
        w_orow = (orow_q == geo_i.out_size   - span_t'(1));
        w_n    = (n_q    == geo_i.cfg.batch  - dim_t'(1));

        iy     = iy_base_q + to_off(kr_q);
        ix     = ix_base_q + to_off(kc_q);
        in_sum = n_off_q + row_off_q + kr_off_q + col_off_q + kc_off_q + to_off(ic_q);

        vld = running_q
              && (iy >= off_t'(0)) && (iy < to_off(geo_i.cfg.in_size))
              && (ix >= off_t'(0)) && (ix < to_off(geo_i.cfg.in_size));
        fst = running_q && (ic_q == '0) && (kc_q == '0) && (kr_q == '0);
        lst = running_q && w_ic && w_kc && w_kr;

        req_o.active     = running_q;
        req_o.valid      = vld;
        req_o.first      = fst;
        req_o.last       = lst;
        req_o.final_step = lst && w_oc && w_ocol && w_orow && w_n;
        req_o.in_addr    = addr_t'(in_sum);
        req_o.ker_addr   = ker_q;
        req_o.out_addr   = out_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            n_q       <= '0;
            oc_q      <= '0;
            kr_q      <= '0;
            kc_q      <= '0;
            ic_q      <= '0;
            orow_q    <= '0;
            ocol_q    <= '0;
            iy_base_q <= '0;
            ix_base_q <= '0;
            n_off_q   <= '0;
            row_off_q <= '0;
            col_off_q <= '0;
            kr_off_q  <= '0;
            kc_off_q  <= '0;
            ker_q     <= '0;
            out_q     <= '0;
        end else if (launch_i) begin
            running_q <= 1'b1;
            n_q       <= '0;
            oc_q      <= '0;
            kr_q      <= '0;
            kc_q      <= '0;
            ic_q      <= '0;
            orow_q    <= '0;
            ocol_q    <= '0;
            iy_base_q <= -to_off(geo_i.cfg.pad);
            ix_base_q <= -to_off(geo_i.cfg.pad);
            n_off_q   <= '0;
            row_off_q <= -geo_i.prow;
            col_off_q <= -geo_i.pcol;
            kr_off_q  <= '0;
            kc_off_q  <= '0;
            ker_q     <= '0;
            out_q     <= '0;
        end else if (running_q) begin
            // Kernel and output layouts follow the loop order, so both are plain counters.
            ker_q <= (lst && w_oc) ? '0 : ker_q + addr_t'(1);
            if (lst) begin
                out_q <= out_q + addr_t'(1);
            end
            if (!w_ic) begin
                ic_q <= ic_q + dim_t'(1);
            end else begin
                ic_q <= '0;
                if (!w_kc) begin
                    kc_q     <= kc_q + dim_t'(1);
                    kc_off_q <= kc_off_q + to_off(geo_i.cfg.in_ch);
                end else begin
                    kc_q     <= '0;
                    kc_off_q <= '0;
                    if (!w_kr) begin
                        kr_q     <= kr_q + dim_t'(1);
                        kr_off_q <= kr_off_q + geo_i.row_pitch;
                    end else begin
                        kr_q     <= '0;
                        kr_off_q <= '0;
                        if (!w_oc) begin
                            oc_q <= oc_q + dim_t'(1);
                        end else begin
                            oc_q <= '0;
                            if (!w_ocol) begin
                                ocol_q    <= ocol_q + span_t'(1);
                                ix_base_q <= ix_base_q + to_off(geo_i.cfg.stride);
                                col_off_q <= col_off_q + geo_i.scol;
                            end else begin
                                ocol_q    <= '0;
                                ix_base_q <= -to_off(geo_i.cfg.pad);
                                col_off_q <= -geo_i.pcol;
                                if (!w_orow) begin
                                    orow_q    <= orow_q + span_t'(1);
                                    iy_base_q <= iy_base_q + to_off(geo_i.cfg.stride);
                                    row_off_q <= row_off_q + geo_i.srow;
                                end else begin
                                    orow_q    <= '0;
                                    iy_base_q <= -to_off(geo_i.cfg.pad);
                                    row_off_q <= -geo_i.prow;
                                    if (!w_n) begin
                                        n_q     <= n_q + dim_t'(1);
                                        n_off_q <= n_off_q + geo_i.img_pitch;
                                    end else begin
                                        running_q <= 1'b0;
                                    end
                                end
                            end
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/conv_seq_mac.sv
module conv_seq_mac
    import conv_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     active_i,
    input  logic                     valid_i,
    input  logic                     first_i,
    input  logic                     last_i,
    input  addr_t                    out_addr_i,
    input  logic signed [DATA_W-1:0] in_data_i,
    input  logic signed [DATA_W-1:0] ker_data_i,
    output logic                     wr_valid_o,
    output addr_t                    wr_addr_o,
    output logic signed [ACC_W-1:0]  wr_data_o
);

    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  acc_next;

    always_comb begin
        prod     = valid_i ? (PROD_W'(in_data_i) * PROD_W'(ker_data_i)) : '0;
        prod_ext = ACC_W'(prod);
        acc_next = (first_i ? '0 : acc_q) + prod_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            wr_valid_o <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
        end else begin
            wr_valid_o <= active_i && last_i;
            if (active_i) begin
                acc_q <= acc_next;
                if (last_i) begin
                    wr_addr_o <= out_addr_i;
                    wr_data_o <= acc_next;
                end
            end
        end
    end

endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [DIM_W-1:0]         cfg_batch,
    input  logic [DIM_W-1:0]         cfg_in_size,
    input  logic [DIM_W-1:0]         cfg_in_ch,
    input  logic [DIM_W-1:0]         cfg_out_ch,
    input  logic [DIM_W-1:0]         cfg_k_size,
    input  logic [DIM_W-1:0]         cfg_stride,
    input  logic [DIM_W-1:0]         cfg_pad,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic signed [DATA_W-1:0] ker_data,
    output logic                     busy,
    output logic                     done,
    output logic                     cfg_err,
    output logic [SPAN_W-1:0]        out_size,
    output logic                     req_active,
    output logic                     req_valid,
    output logic                     req_first,
    output logic                     req_last,
    output logic [ADDR_W-1:0]        in_addr,
    output logic [ADDR_W-1:0]        ker_addr,
    output logic [ADDR_W-1:0]        out_addr,
    output logic                     wr_valid,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic signed [ACC_W-1:0]  wr_data
);

    cfg_t cfg_in;
    geo_t geo;
    req_t req;
    logic launch;
    logic setup_busy;
    logic drain_q;
    logic done_q;

    assign cfg_in = '{batch:   cfg_batch,
                      in_size: cfg_in_size,
                      in_ch:   cfg_in_ch,
                      out_ch:  cfg_out_ch,
                      k_size:  cfg_k_size,
                      stride:  cfg_stride,
                      pad:     cfg_pad};

    conv_seq_setup u_setup (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .idle_i   (!busy),
        .cfg_i    (cfg_in),
        .geo_o    (geo),
        .launch_o (launch),
        .err_o    (cfg_err),
        .busy_o   (setup_busy)
    );

    conv_seq_walker u_walker (
        .clk      (clk),
        .rst      (rst),
        .launch_i (launch),
        .geo_i    (geo),
        .req_o    (req)
    );

    conv_seq_mac #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
    ) u_mac (
        .clk        (clk),
        .rst        (rst),
        .active_i   (req.active),
        .valid_i    (req.valid),
        .first_i    (req.first),
        .last_i     (req.last),
        .out_addr_i (req.out_addr),
        .in_data_i  (in_data),
        .ker_data_i (ker_data),
        .wr_valid_o (wr_valid),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    // drain_q marks the cycle of the final write; done follows it.
    always_ff @(posedge clk) begin
        if (rst) begin
            drain_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            drain_q <= req.active && req.final_step;
            done_q  <= drain_q;
        end
    end

    assign busy       = setup_busy | launch | req.active | drain_q;
    assign done       = done_q;
    assign out_size   = geo.out_size;
    assign req_active = req.active;
    assign req_valid  = req.valid;
    assign req_first  = req.first;
    assign req_last   = req.last;
    assign in_addr    = req.in_addr;
    assign ker_addr   = req.ker_addr;
    assign out_addr   = req.out_addr;

endmodule

// File: rtl/conv_seq_checker.sv
module conv_seq_checker
    import conv_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              cfg_err,
    input logic              req_active,
    input logic              req_valid,
    input logic              req_first,
    input logic              req_last,
    input logic [ADDR_W-1:0] out_addr,
    input logic              wr_valid
);

    assert_steps_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
        req_active |-> busy);

    assert_valid_in_step_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_active);

    assert_out_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (req_active && $past(req_active) && !$past(req_last)) |-> $stable(out_addr));

    assert_out_addr_next_R5: assert property (@(posedge clk) disable iff (rst)
        (req_active && $past(req_active) && $past(req_last)) |-> (out_addr == $past(out_addr) + ADDR_W'(1)));

    assert_first_after_last_R6: assert property (@(posedge clk) disable iff (rst)
        (req_active && $past(req_active)) |-> (req_first == $past(req_last)));

    assert_write_follows_last_R7: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(req_active && req_last));

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_valid) && !busy));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_no_run_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!req_active && !wr_valid && !done));

endmodule

bind conv_seq conv_seq_checker u_conv_seq_checker (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .cfg_err    (cfg_err),
    .req_active (req_active),
    .req_valid  (req_valid),
    .req_first  (req_first),
    .req_last   (req_last),
    .out_addr   (out_addr),
    .wr_valid   (wr_valid)
);

// File: tb/conv_seq_bench.sv
`timescale 1ns/1ps
module conv_seq_bench;
    import conv_seq_pkg::*;

    localparam int DATA_W = 8;
    localparam int ACC_W  = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [DIM_W-1:0] cfg_batch = '0, cfg_in_size = '0, cfg_in_ch = '0, cfg_out_ch = '0;
    logic [DIM_W-1:0] cfg_k_size = '0, cfg_stride = '0, cfg_pad = '0;
    logic signed [DATA_W-1:0] in_data, ker_data;
    logic busy, done, cfg_err, req_active, req_valid, req_first, req_last, wr_valid;
    logic [SPAN_W-1:0] out_size;
    logic [ADDR_W-1:0] in_addr, ker_addr, out_addr, wr_addr;
    logic signed [ACC_W-1:0] wr_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    function automatic int fin(int a);
        return ((a * 37 + 11) % 29) - 14;
    endfunction

    function automatic int fker(int a);
        return ((a * 13 + 5) % 11) - 5;
    endfunction

    assign in_data  = DATA_W'(fin(int'(in_addr)));
    assign ker_data = DATA_W'(fker(int'(ker_addr)));

    conv_seq #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_conv_seq (
        .clk(clk), .rst(rst), .start(start),
        .cfg_batch(cfg_batch), .cfg_in_size(cfg_in_size), .cfg_in_ch(cfg_in_ch),
        .cfg_out_ch(cfg_out_ch), .cfg_k_size(cfg_k_size), .cfg_stride(cfg_stride),
        .cfg_pad(cfg_pad), .in_data(in_data), .ker_data(ker_data),
        .busy(busy), .done(done), .cfg_err(cfg_err), .out_size(out_size),
        .req_active(req_active), .req_valid(req_valid), .req_first(req_first),
        .req_last(req_last), .in_addr(in_addr), .ker_addr(ker_addr), .out_addr(out_addr),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check_eq(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL R8 watchdog actual=%0d expected=done", cycles);
                report();
            end
        end
    end

    task automatic drive_cfg(int n, int id, int ic, int oc, int k, int s, int p);
        cfg_batch   = DIM_W'(n);
        cfg_in_size = DIM_W'(id);
        cfg_in_ch   = DIM_W'(ic);
        cfg_out_ch  = DIM_W'(oc);
        cfg_k_size  = DIM_W'(k);
        cfg_stride  = DIM_W'(s);
        cfg_pad     = DIM_W'(p);
    endtask

    task automatic test_reset();
        // R1: state while reset is held and just after release
        check_eq("R1", "busy", busy, 0);
        check_eq("R1", "done", done, 0);
        check_eq("R1", "cfg_err", cfg_err, 0);
        check_eq("R1", "req_active", req_active, 0);
        check_eq("R1", "req_valid", req_valid, 0);
        check_eq("R1", "req_first", req_first, 0);
        check_eq("R1", "req_last", req_last, 0);
        check_eq("R1", "wr_valid", wr_valid, 0);
        check_eq("R1", "out_size", out_size, 0);
    endtask

    task automatic run_conv(int n, int id, int ic, int oc, int k, int s, int p, bit mid);
        int od, waitc, idx, acc, iy, ix, exp_in;
        bit vld, pend;
        int pend_addr, pend_data;
        od = (id + 2 * p - k) / s + 1;
        pend = 0; pend_addr = 0; pend_data = 0; acc = 0; idx = 0;
        @(negedge clk);
        drive_cfg(n, id, ic, oc, k, s, p);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R9", "cfg_err cleared by good start", cfg_err, 0);
        waitc = 0;
        while (!req_active && waitc < 3000) begin
            @(negedge clk);
            waitc++;
        end
        check_eq("R2", "out_size", out_size, od);
        for (int b = 0; b < n; b++)
        for (int orow = 0; orow < od; orow++)
        for (int ocol = 0; ocol < od; ocol++)
        for (int och = 0; och < oc; och++)
        for (int kr = 0; kr < k; kr++)
        for (int kc = 0; kc < k; kc++)
        for (int ich = 0; ich < ic; ich++) begin
            iy = orow * s + kr - p;
            ix = ocol * s + kc - p;
            vld = (iy >= 0) && (iy < id) && (ix >= 0) && (ix < id);
            if (pend) begin
                check_eq("R7", "wr_valid after last", wr_valid, 1);
                check_eq("R7", "wr_addr", wr_addr, pend_addr);
                check_eq("R7", "wr_data", $signed(wr_data), pend_data);
                pend = 0;
            end else begin
                check_eq("R7", "wr_valid idle", wr_valid, 0);
            end
            check_eq("R3", "req_active", req_active, 1);
            check_eq("R2", "out_size hold", out_size, od);
            check_eq("R4", "req_valid", req_valid, vld);
            if (vld) begin
                exp_in = ((b * id + iy) * id + ix) * ic + ich;
                check_eq("R4", "in_addr", in_addr, exp_in);
                acc += fin(exp_in) * fker(((och * k + kr) * k + kc) * ic + ich);
            end
            check_eq("R5", "ker_addr", ker_addr, ((och * k + kr) * k + kc) * ic + ich);
            check_eq("R5", "out_addr", out_addr, ((b * od + orow) * od + ocol) * oc + och);
            check_eq("R6", "req_first", req_first, (kr == 0 && kc == 0 && ich == 0));
            check_eq("R6", "req_last", req_last, (kr == k - 1 && kc == k - 1 && ich == ic - 1));
            if (kr == k - 1 && kc == k - 1 && ich == ic - 1) begin
                pend = 1;
                pend_addr = ((b * od + orow) * od + ocol) * oc + och;
                pend_data = acc;
                acc = 0;
            end
            if (mid && idx == 10) begin
                start = 1'b1;
                cfg_stride = '0;
            end
            if (idx == 11) start = 1'b0;
            idx++;
            @(negedge clk);
        end
        start = 1'b0;
        check_eq("R7", "final wr_valid", wr_valid, 1);
        check_eq("R7", "final wr_addr", wr_addr, pend_addr);
        check_eq("R7", "final wr_data", $signed(wr_data), pend_data);
        check_eq("R3", "req_active after last step", req_active, 0);
        check_eq("R8", "done early", done, 0);
        @(negedge clk);
        check_eq("R8", "done pulse", done, 1);
        check_eq("R8", "busy at done", busy, 0);
        check_eq("R7", "wr_valid at done", wr_valid, 0);
        @(negedge clk);
        check_eq("R8", "done single", done, 0);
        if (mid) check_eq("R10", "cfg_err after ignored start", cfg_err, 0);
    endtask

    task automatic run_bad(int id, int k, int s, int p);
        int bad;
        @(negedge clk);
        drive_cfg(1, id, 1, 1, k, s, p);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R9", "cfg_err set", cfg_err, 1);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            if (busy || req_active || wr_valid || done) bad++;
            @(negedge clk);
        end
        check_eq("R9", "activity after rejected start", bad, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_conv(1, 4, 2, 2, 3, 1, 0, 0);
        run_conv(2, 5, 1, 2, 3, 2, 1, 0);
        run_conv(1, 2, 2, 1, 1, 1, 2, 0);
        run_conv(1, 7, 3, 3, 2, 3, 0, 0);
        run_bad(4, 3, 0, 1);
        run_bad(2, 6, 1, 1);
        run_conv(1, 3, 1, 1, 3, 1, 1, 0);
        run_conv(1, 4, 2, 2, 3, 1, 1, 1);
        report();
    end

endmodule